// File: doc/BRIEF.md
# I2C Slave Register Control Port

This block is a bus-slave front end that lets an external I2C master read and write a small bank of control registers. It never starts a transfer. It watches the clock and data lines in the system clock domain and recognises start and stop conditions. It answers only to its fixed 7-bit device address. Once addressed for a write, it takes one subaddress byte and then data bytes. It acknowledges every byte it accepts by pulling the data line low during the ninth clock.

Registers are grouped into words. The low half of the register space holds one-byte words. The upper half holds two-byte words. A word reaches the register bank only when its last byte has arrived. After each complete word the subaddress moves forward by that word's length, so a burst can fill contiguous registers without resending the address. A read uses the same pointer: the master writes the subaddress, issues a repeated start with the read flag, and the slave shifts bytes out MSB first until the master declines a byte.

The whole register bank is presented as a flat output vector, so the functions the registers control can use it directly.

Top module: `i2c_reg_port`

## Requirements
- R1: A falling data line while the clock line is high starts a transfer. A rising data line while the clock line is high ends it. After a stop the data line is released.
- R2: The first byte after a start is acknowledged only when its upper seven bits equal 0x1A, i.e. byte 0x34 for a write or 0x35 for a read. Any other value gets no acknowledge, and the rest of that transfer gets none either, up to the next start.
- R3: In a write, the subaddress byte and every data byte are acknowledged by pulling the data line low during the ninth clock.
- R4: Only the low four bits of the subaddress byte select a register (16 registers). The upper four bits are ignored.
- R5: Registers 0 to 7 are one-byte words. Registers 8 to 15 are two-byte words: the first data byte goes to the addressed register and the second to the register after it.
- R6: A word is written into the bank only after all of its bytes have arrived. A word cut short by a stop leaves the bank unchanged.
- R7: After each complete word the subaddress advances by that word's length, wrapping modulo 16, so a burst write fills consecutive registers.
- R8: After a write of the subaddress and a repeated start with byte 0x35, the slave sends register bytes MSB first, starting at the subaddress and advancing as in R7. It continues while the master acknowledges. A master non-acknowledge ends the read and releases the data line.
- R9: After reset all registers read zero and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level (wired value) |
| sdaPullLow | output | 1 | 1 pulls the data line low (open-drain drive) |
| regBank | output | 128 | Register contents, register n at bits 8n+7..8n |

## Verification
A wrong bit counter or a wrong control state shows up within one byte time. The acknowledge then lands on the wrong clock, or a read bit arrives shifted. The master sees either one at its ninth-clock sample. A wrong subaddress pointer or a wrong byte index inside a word stays hidden until a word completes. It then shows as a byte landing in a neighbouring register on the register output, or as a read returning the wrong register. The directed scenarios therefore end every write with a full comparison of the register output, and read back across a word-length boundary.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } busState_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_SUB,
    PH_WR
  } phase_t;

  typedef struct packed {
    logic shiftIn;
    logic setAddr;
    logic stageByte;
    logic loadTx;
    logic shiftTx;
    logic advanceRead;
    logic dropWord;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic [1:0] sclSync;
  logic [1:0] sdaSync;
  logic sclD;
  logic sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclD    <= sclSync[1];
      sdaD    <= sdaSync[1];
    end
  end

  assign sdaLevel  = sdaSync[1];
  assign sclRise   = sclSync[1] & ~sclD;
  assign sclFall   = ~sclSync[1] & sclD;
  assign startSeen = sclSync[1] & sclD & sdaD & ~sdaSync[1];
  assign stopSeen  = sclSync[1] & sclD & ~sdaD & sdaSync[1];

endmodule

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1A
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sdaLevel,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startSeen,
  input  logic      stopSeen,
  input  logic [7:0] rxByte,
  input  logic      txBit,
  output dpStrobe_t stb,
  output logic      sdaLow
);

  busState_t state, stateN;
  phase_t    phase, phaseN;
  logic [2:0] bitCnt, cntN;
  logic rxFull, fullN;
  logic rwRead, rwN;
  logic mAck, mAckN;
  logic ackLow, lowN;

  always_comb begin
    stb    = '0;
    stateN = state;
    phaseN = phase;
    cntN   = bitCnt;
    fullN  = rxFull;
    rwN    = rwRead;
    mAckN  = mAck;
    lowN   = ackLow;
    if (startSeen) begin
      stateN = ST_RX;
      phaseN = PH_DEV;
      cntN   = 3'd0;
      fullN  = 1'b0;
      lowN   = 1'b0;
      stb.dropWord = 1'b1;
    end else if (stopSeen) begin
      stateN = ST_IDLE;
      fullN  = 1'b0;
      lowN   = 1'b0;
      stb.dropWord = 1'b1;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise && !rxFull) begin
            stb.shiftIn = 1'b1;
            cntN = bitCnt + 3'd1;
            if (bitCnt == 3'd7) fullN = 1'b1;
          end else if (sclFall && rxFull) begin
            fullN = 1'b0;
            cntN  = 3'd0;
            case (phase)
              PH_DEV: begin
                if (rxByte[7:1] == DEV_ADDR) begin
                  rwN    = rxByte[0];
                  stateN = ST_ACK;
                  lowN   = 1'b1;
                end else begin
                  stateN = ST_IDLE;
                end
              end
              PH_SUB: begin
                stb.setAddr = 1'b1;
                stateN = ST_ACK;
                lowN   = 1'b1;
              end
              default: begin
                stb.stageByte = 1'b1;
                stateN = ST_ACK;
                lowN   = 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            lowN = 1'b0;
            cntN = 3'd0;
            if (phase == PH_DEV && rwRead) begin
              stb.loadTx = 1'b1;
              stateN = ST_TX;
            end else begin
              stateN = ST_RX;
              phaseN = (phase == PH_DEV) ? PH_SUB : PH_WR;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 3'd7) begin
              stateN = ST_MACK;
              stb.advanceRead = 1'b1;
            end else begin
              stb.shiftTx = 1'b1;
              cntN = bitCnt + 3'd1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            mAckN = ~sdaLevel;
          end else if (sclFall) begin
            cntN = 3'd0;
            if (mAck) begin
              stb.loadTx = 1'b1;
              stateN = ST_TX;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= PH_DEV;
      bitCnt <= 3'd0;
      rxFull <= 1'b0;
      rwRead <= 1'b0;
      mAck   <= 1'b0;
      ackLow <= 1'b0;
    end else begin
      state  <= stateN;
      phase  <= phaseN;
      bitCnt <= cntN;
      rxFull <= fullN;
      rwRead <= rwN;
      mAck   <= mAckN;
      ackLow <= lowN;
    end
  end

  assign sdaLow = ackLow | ((state == ST_TX) & ~txBit);

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaLow);

  // R2
  nomatch_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RX && phase == PH_DEV && rxFull && sclFall && !startSeen &&
     !stopSeen && rxByte[7:1] != DEV_ADDR) |=> (state == ST_IDLE && !sdaLow));

  // R3
  ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackLow) |-> $past(rxFull));

  // R8
  tx_only_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TX) |-> rwRead);

endmodule

// File: rtl/i2c_reg_data.sv
module i2c_reg_data
  import i2c_reg_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int WIDE_BASE  = 8,
  parameter int WIDE_BYTES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             stb,
  input  logic                  sdaLevel,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic [NUM_REGS*8-1:0] bankFlat
);

  localparam int ADDR_W = $clog2(NUM_REGS);
  localparam int IDX_W  = $clog2(WIDE_BYTES) + 1;

  logic [7:0]        rxShift;
  logic [7:0]        txShift;
  logic [ADDR_W-1:0] subAddr;
  logic [IDX_W-1:0]  byteIdx;
  logic [7:0]        wordBuf [WIDE_BYTES];
  logic [IDX_W-1:0]  wordLen;
  logic              lastByte;
  logic [ADDR_W-1:0] curPtr;
  logic              commit;

  assign wordLen  = (subAddr >= ADDR_W'(WIDE_BASE)) ? IDX_W'(WIDE_BYTES) : IDX_W'(1);
  assign lastByte = (byteIdx == wordLen - IDX_W'(1));
  assign curPtr   = subAddr + ADDR_W'(byteIdx);
  assign commit   = stb.stageByte & lastByte;
  assign rxByte   = rxShift;
  assign txBit    = txShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= 8'h00;
      txShift <= 8'hFF;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[6:0], sdaLevel};
      if (stb.loadTx) txShift <= bankFlat[{curPtr, 3'b000} +: 8];
      else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subAddr <= '0;
      byteIdx <= '0;
      for (int i = 0; i < WIDE_BYTES; i++) wordBuf[i] <= 8'h00;
    end else if (stb.dropWord) begin
      byteIdx <= '0;
    end else if (stb.setAddr) begin
      subAddr <= rxShift[ADDR_W-1:0];
      byteIdx <= '0;
    end else if (stb.stageByte || stb.advanceRead) begin
      if (lastByte) begin
        subAddr <= subAddr + ADDR_W'(wordLen);
        byteIdx <= '0;
      end else begin
        byteIdx <= byteIdx + IDX_W'(1);
      end
      if (stb.stageByte) begin
        for (int i = 0; i < WIDE_BYTES; i++)
          if (byteIdx == IDX_W'(i)) wordBuf[i] <= rxShift;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic       hit;
    logic [7:0] newVal;
    logic [7:0] regQ;

    always_comb begin
      hit    = 1'b0;
      newVal = regQ;
      for (int i = 0; i < WIDE_BYTES; i++) begin
        if (IDX_W'(i) < wordLen && (subAddr + ADDR_W'(i)) == ADDR_W'(g)) begin
          hit    = 1'b1;
          newVal = (IDX_W'(i) == byteIdx) ? rxShift : wordBuf[i];
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regQ <= 8'h00;
      else if (commit && hit) regQ <= newVal;
    end

    assign bankFlat[g*8 +: 8] = regQ;
  end

  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.stageByte |=> $stable(bankFlat));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.setAddr || stb.stageByte || stb.advanceRead) |=> $stable(subAddr));

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteIdx < wordLen);

endmodule

// File: rtl/i2c_reg_port.sv
module i2c_reg_port
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h1A,
  parameter int         NUM_REGS   = 16,
  parameter int         WIDE_BASE  = 8,
  parameter int         WIDE_BYTES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaPullLow,
  output logic [NUM_REGS*8-1:0] regBank
);

  logic sdaLevel, sclRise, sclFall, startSeen, stopSeen;
  logic [7:0] rxByte;
  logic txBit;
  dpStrobe_t stb;

  i2c_bus_sense uSense (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sdaLevel (sdaLevel),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startSeen(startSeen),
    .stopSeen (stopSeen)
  );

  i2c_reg_ctrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sdaLevel (sdaLevel),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startSeen(startSeen),
    .stopSeen (stopSeen),
    .rxByte   (rxByte),
    .txBit    (txBit),
    .stb      (stb),
    .sdaLow   (sdaPullLow)
  );

  i2c_reg_data #(
    .NUM_REGS  (NUM_REGS),
    .WIDE_BASE (WIDE_BASE),
    .WIDE_BYTES(WIDE_BYTES)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .sdaLevel(sdaLevel),
    .rxByte  (rxByte),
    .txBit   (txBit),
    .bankFlat(regBank)
  );

endmodule

// File: tb/i2c_reg_port_test.sv
module i2c_reg_port_test;

  localparam int Q = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaPullLow;
  logic [127:0] regBank;
  wire  sdaBus = mSda & ~sdaPullLow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] expBank [16];

  always #2 clk = ~clk;

  i2c_reg_port uut (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (mScl),
    .sdaIn     (sdaBus),
    .sdaPullLow(sdaPullLow),
    .regBank   (regBank)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitQ();
      mScl = 1'b1; waitQ(); waitQ();
      mScl = 1'b0; waitQ();
    end
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    ack = ~sdaBus;
    waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic getByte(input bit ackIt, output logic [7:0] d);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      mScl = 1'b1; waitQ();
      d[i] = sdaBus;
      waitQ();
      mScl = 1'b0;
    end
    waitQ();
    mSda = ~ackIt; waitQ();
    mScl = 1'b1; waitQ(); waitQ();
    mScl = 1'b0; waitQ();
    mSda = 1'b1;
  endtask

  task automatic checkBank(input string req);
    for (int r = 0; r < 16; r++)
      check(regBank[r*8 +: 8] == expBank[r], req, 32'(regBank[r*8 +: 8]), 32'(expBank[r]));
  endtask

  task automatic testReset();
    for (int r = 0; r < 16; r++) expBank[r] = 8'h00;
    check(sdaPullLow == 1'b0, "R9 released", 32'(sdaPullLow), 0);
    checkBank("R9 bank zero");
  endtask

  task automatic testSingleWrite();
    logic ack;
    busStart();
    sendByte(8'h34, ack); check(ack, "R2 write addr ack", 32'(ack), 1);
    sendByte(8'h03, ack); check(ack, "R3 subaddr ack", 32'(ack), 1);
    sendByte(8'hA5, ack); check(ack, "R3 data ack", 32'(ack), 1);
    busStop();
    expBank[3] = 8'hA5;
    check(sdaPullLow == 1'b0, "R1 release after stop", 32'(sdaPullLow), 0);
    checkBank("R5 single byte word");
  endtask

  task automatic testWrongAddr();
    logic ack;
    busStart();
    sendByte(8'h36, ack); check(!ack, "R2 wrong addr nack", 32'(ack), 0);
    sendByte(8'h03, ack); check(!ack, "R2 ignored subaddr", 32'(ack), 0);
    sendByte(8'h11, ack); check(!ack, "R2 ignored data", 32'(ack), 0);
    busStop();
    checkBank("R2 bank untouched");
  endtask

  task automatic testHighBits();
    logic ack;
    busStart();
    sendByte(8'h34, ack);
    sendByte(8'h15, ack); check(ack, "R4 subaddr ack", 32'(ack), 1);
    sendByte(8'h3C, ack);
    busStop();
    expBank[5] = 8'h3C;
    checkBank("R4 upper bits ignored");
  endtask

  task automatic testWide();
    logic ack;
    busStart();
    sendByte(8'h34, ack);
    sendByte(8'h0A, ack);
    sendByte(8'h12, ack); check(ack, "R3 wide byte0 ack", 32'(ack), 1);
    check(regBank[10*8 +: 8] == 8'h00, "R6 no early commit", 32'(regBank[10*8 +: 8]), 0);
    sendByte(8'h34, ack); check(ack, "R3 wide byte1 ack", 32'(ack), 1);
    busStop();
    expBank[10] = 8'h12;
    expBank[11] = 8'h34;
    checkBank("R5 two byte word");
  endtask

  task automatic testPartial();
    logic ack;
    busStart();
    sendByte(8'h34, ack);
    sendByte(8'h0C, ack);
    sendByte(8'h77, ack); check(ack, "R3 partial byte ack", 32'(ack), 1);
    busStop();
    checkBank("R6 partial word dropped");
  endtask

  task automatic testBurst();
    logic ack;
    busStart();
    sendByte(8'h34, ack);
    sendByte(8'h06, ack);
    for (int k = 1; k <= 6; k++) begin
      sendByte(8'(k), ack);
      check(ack, "R3 burst data ack", 32'(ack), 1);
    end
    busStop();
    for (int k = 0; k < 6; k++) expBank[6 + k] = 8'(k + 1);
    checkBank("R7 burst increment");
  endtask

  task automatic testWrap();
    logic ack;
    busStart();
    sendByte(8'h34, ack);
    sendByte(8'h0E, ack);
    sendByte(8'hAA, ack);
    sendByte(8'hBB, ack);
    sendByte(8'hCC, ack);
    busStop();
    expBank[14] = 8'hAA;
    expBank[15] = 8'hBB;
    expBank[0]  = 8'hCC;
    checkBank("R7 wrap to zero");
  endtask

  task automatic testRead();
    logic ack;
    logic [7:0] d;
    busStart();
    sendByte(8'h34, ack);
    sendByte(8'h06, ack);
    busStart();
    sendByte(8'h35, ack); check(ack, "R8 read addr ack", 32'(ack), 1);
    for (int k = 0; k < 4; k++) begin
      getByte(k != 3, d);
      check(d == expBank[6 + k], "R8 read data", 32'(d), 32'(expBank[6 + k]));
    end
    check(sdaPullLow == 1'b0, "R8 released after nack", 32'(sdaPullLow), 0);
    busStop();
    check(sdaPullLow == 1'b0, "R1 release after read stop", 32'(sdaPullLow), 0);
    checkBank("R8 read leaves bank");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testSingleWrite();
    testWrongAddr();
    testHighBits();
    testWide();
    testPartial();
    testBurst();
    testWrap();
    testRead();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule